// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block holds the forwarding-window configuration of a PCI-to-PCI bridge and tells the surrounding logic which window, if any, claims an address. Software programs it through a 32-bit configuration port with byte enables. That port covers the command and bridge-control words, the bus numbers and latency timer, and three address windows. The three windows are an I/O window, a non-prefetchable memory window and a prefetchable memory window.

Each window is rebuilt from its base and limit registers at its own granularity. The I/O window is 4 KB aligned and can extend to 32 bits. The memory window is 1 MB aligned and 32 bits wide. The prefetchable window is 1 MB aligned and can extend to 64 bits. Each window is qualified by the matching space-enable bit in the command word. A window whose limit lies below its base claims nothing.

A decode query takes an address and a space flag and returns a hit code with no clock delay. Setting the reset bit in bridge control from 0 to 1 produces a one-cycle reset pulse toward the secondary side. A separate strobe closes all three windows at once.

Top module: `bridge_window_decoder`

Register words (index on `cfg_addr`):

| Word | Bits 31:16 | Bits 15:0 |
|---|---|---|
| 0 | bridge control; bit 22 (control bit 6) is the secondary reset | command; bit 0 I/O enable, bit 1 memory enable |
| 1 | bits 31:24 latency timer, bits 23:16 subordinate bus | bits 15:8 secondary bus, bits 7:0 primary bus |
| 2 | zero | limit byte in bits 15:8, base byte in bits 7:0; address nibble in bits 7:4 of each byte, type nibble in bits 3:0 |
| 3 | I/O limit bits 31:16 | I/O base bits 31:16 |
| 4 | memory limit word | memory base word; address in bits 15:4 of each half, type nibble 0 |
| 5 | prefetchable limit word | prefetchable base word; same layout as word 4 |
| 6 | prefetchable base bits 63:32 | |
| 7 | prefetchable limit bits 63:32 | |

## Requirements
- R1: After reset, all eight words read zero, except for the read-only type nibbles. These read 1 when the matching wide variant is enabled, so by default word 2 reads 0x00000101 and word 5 reads 0x00010001.
- R2: A write changes only the bytes whose enable is set. Type nibbles and the reserved upper half of word 2 ignore writes. With the defaults, writing 0xFFFFFFFF to word 2 reads back 0x0000F1F1.
- R3: The I/O window spans from {upper base, base nibble, 0x000} to {upper limit, limit nibble, 0xFFF}. It claims only I/O queries whose address bits 63:32 are zero.
- R4: The memory window spans from {base bits 15:4, 20 zero bits} to {limit bits 15:4, 0xFFFFF}. It claims only memory queries whose address bits 63:32 are zero.
- R5: The prefetchable window is formed like the memory window, with words 6 and 7 supplying bits 63:32. It compares all 64 address bits.
- R6: The I/O window claims only while command bit 0 is set. Both memory windows claim only while command bit 1 is set.
- R7: A window whose limit is below its base claims no address.
- R8: The hit code is 0 for none, 1 for I/O, 2 for memory and 3 for prefetchable. Where the memory and prefetchable windows overlap, code 3 is reported.
- R9: The cycle after a write that sets control bit 22 while it was 0, the secondary reset pulse is high for exactly one cycle. Writing 1 while the bit is already 1 gives no pulse.
- R10: A disable strobe sets every base address bit to one and clears every limit address bit and both upper prefetchable words. After it, no window claims anything.
- R11: A single write that moves both base and limit of a window takes effect completely in the next cycle, with no intermediate window ever visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_wr | input | 1 | configuration write strobe |
| cfg_addr | input | 3 | register word index for read and write |
| cfg_be | input | 4 | byte enables of the write |
| cfg_wdata | input | 32 | write data |
| cfg_rdata | output | 32 | read data of the addressed word, combinational |
| fwd_off | input | 1 | disable strobe; closes all windows and takes priority over a write |
| dec_addr | input | 64 | address to decode |
| dec_io | input | 1 | 1 for an I/O query, 0 for a memory query |
| dec_hit | output | 2 | hit code |
| sbr_pulse | output | 1 | secondary bus reset pulse |

## Verification
The hardest case to reach is an address that lies exactly on a window edge while another window, the command enables or the wide-address extensions also bear on the answer. Examples are the prefetchable window inside the memory window, or a prefetchable limit reaching above 4 GB. Random decode queries are therefore drawn mostly from the current base and limit values of each window, plus or minus one, and these are mixed with random partial writes. Directed sequences build overlapping, inverted and 64-bit windows, and they repeat writes of the reset bit to separate a rising edge from a write that leaves the bit unchanged.

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder #(
  parameter bit IO32   = 1'b1,
  parameter bit PREF64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        fwd_off,
  input  logic [63:0] dec_addr,
  input  logic        dec_io,
  output logic [1:0]  dec_hit,
  output logic        sbr_pulse
);

  localparam logic [3:0] IOT = IO32 ? 4'h1 : 4'h0;
  localparam logic [3:0] PFT = PREF64 ? 4'h1 : 4'h0;

  logic [15:0] cmd, ctrl;
  logic [7:0]  pbus, sbus, subus, lat;
  logic [3:0]  io_bn, io_ln;
  logic [15:0] io_bu, io_lu;
  logic [11:0] mem_b, mem_l, pf_b, pf_l;
  logic [31:0] pf_bu, pf_lu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0; ctrl <= '0;
      pbus <= '0; sbus <= '0; subus <= '0; lat <= '0;
      io_bn <= '0; io_ln <= '0; io_bu <= '0; io_lu <= '0;
      mem_b <= '0; mem_l <= '0; pf_b <= '0; pf_l <= '0;
      pf_bu <= '0; pf_lu <= '0;
      sbr_pulse <= 1'b0;
    end else begin
      sbr_pulse <= 1'b0;
      if (fwd_off) begin
        io_bn <= 4'hF; io_ln <= 4'h0;
        io_bu <= IO32 ? 16'hFFFF : 16'h0000; io_lu <= '0;
        mem_b <= 12'hFFF; mem_l <= '0;
        pf_b <= 12'hFFF; pf_l <= '0;
        pf_bu <= '0; pf_lu <= '0;
      end else if (cfg_wr) begin
        case (cfg_addr)
          3'd0: begin
            if (cfg_be[0]) cmd[7:0]   <= cfg_wdata[7:0];
            if (cfg_be[1]) cmd[15:8]  <= cfg_wdata[15:8];
            if (cfg_be[2]) ctrl[7:0]  <= cfg_wdata[23:16];
            if (cfg_be[3]) ctrl[15:8] <= cfg_wdata[31:24];
            sbr_pulse <= cfg_be[2] && cfg_wdata[22] && !ctrl[6];
          end
          3'd1: begin
            if (cfg_be[0]) pbus  <= cfg_wdata[7:0];
            if (cfg_be[1]) sbus  <= cfg_wdata[15:8];
            if (cfg_be[2]) subus <= cfg_wdata[23:16];
            if (cfg_be[3]) lat   <= cfg_wdata[31:24];
          end
          3'd2: begin
            if (cfg_be[0]) io_bn <= cfg_wdata[7:4];
            if (cfg_be[1]) io_ln <= cfg_wdata[15:12];
          end
          3'd3: if (IO32) begin
            if (cfg_be[0]) io_bu[7:0]  <= cfg_wdata[7:0];
            if (cfg_be[1]) io_bu[15:8] <= cfg_wdata[15:8];
            if (cfg_be[2]) io_lu[7:0]  <= cfg_wdata[23:16];
            if (cfg_be[3]) io_lu[15:8] <= cfg_wdata[31:24];
          end
          3'd4: begin
            if (cfg_be[0]) mem_b[3:0]  <= cfg_wdata[7:4];
            if (cfg_be[1]) mem_b[11:4] <= cfg_wdata[15:8];
            if (cfg_be[2]) mem_l[3:0]  <= cfg_wdata[23:20];
            if (cfg_be[3]) mem_l[11:4] <= cfg_wdata[31:24];
          end
          3'd5: begin
            if (cfg_be[0]) pf_b[3:0]  <= cfg_wdata[7:4];
            if (cfg_be[1]) pf_b[11:4] <= cfg_wdata[15:8];
            if (cfg_be[2]) pf_l[3:0]  <= cfg_wdata[23:20];
            if (cfg_be[3]) pf_l[11:4] <= cfg_wdata[31:24];
          end
          3'd6: if (PREF64) begin
            if (cfg_be[0]) pf_bu[7:0]   <= cfg_wdata[7:0];
            if (cfg_be[1]) pf_bu[15:8]  <= cfg_wdata[15:8];
            if (cfg_be[2]) pf_bu[23:16] <= cfg_wdata[23:16];
            if (cfg_be[3]) pf_bu[31:24] <= cfg_wdata[31:24];
          end
          3'd7: if (PREF64) begin
            if (cfg_be[0]) pf_lu[7:0]   <= cfg_wdata[7:0];
            if (cfg_be[1]) pf_lu[15:8]  <= cfg_wdata[15:8];
            if (cfg_be[2]) pf_lu[23:16] <= cfg_wdata[23:16];
            if (cfg_be[3]) pf_lu[31:24] <= cfg_wdata[31:24];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0: cfg_rdata = {ctrl, cmd};
      3'd1: cfg_rdata = {lat, subus, sbus, pbus};
      3'd2: cfg_rdata = {16'h0000, io_ln, IOT, io_bn, IOT};
      3'd3: cfg_rdata = {io_lu, io_bu};
      3'd4: cfg_rdata = {mem_l, 4'h0, mem_b, 4'h0};
      3'd5: cfg_rdata = {pf_l, PFT, pf_b, PFT};
      3'd6: cfg_rdata = pf_bu;
      default: cfg_rdata = pf_lu;
    endcase
  end

  wire [31:0] io_base  = {(IO32 ? io_bu : 16'h0000), io_bn, 12'h000};
  wire [31:0] io_lim   = {(IO32 ? io_lu : 16'h0000), io_ln, 12'hFFF};
  wire [31:0] mem_base = {mem_b, 20'h00000};
  wire [31:0] mem_lim  = {mem_l, 20'hFFFFF};
  wire [63:0] pf_base  = {(PREF64 ? pf_bu : 32'h0), pf_b, 20'h00000};
  wire [63:0] pf_lim   = {(PREF64 ? pf_lu : 32'h0), pf_l, 20'hFFFFF};

  wire lo4g   = (dec_addr[63:32] == 32'h0);
  wire io_hit = dec_io && cmd[0] && lo4g && (io_lim >= io_base) &&
                (dec_addr[31:0] >= io_base) && (dec_addr[31:0] <= io_lim);
  wire mem_hit = !dec_io && cmd[1] && lo4g && (mem_lim >= mem_base) &&
                 (dec_addr[31:0] >= mem_base) && (dec_addr[31:0] <= mem_lim);
  wire pf_hit = !dec_io && cmd[1] && (pf_lim >= pf_base) &&
                (dec_addr >= pf_base) && (dec_addr <= pf_lim);

  assign dec_hit = pf_hit ? 2'd3 : mem_hit ? 2'd2 : io_hit ? 2'd1 : 2'd0;

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_pulse |=> !sbr_pulse);
  a_r9_rising_only: assert property (@(posedge clk) disable iff (!rst_n)
    sbr_pulse |-> (ctrl[6] && !$past(ctrl[6])));
  a_r6_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit == 2'd1) |-> (cmd[0] && dec_io));
  a_r6_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit[1] |-> (cmd[1] && !dec_io));
  a_r10_closed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fwd_off) |-> (dec_hit == 2'd0));
  a_r7_io_order: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit == 2'd1) |-> (io_lim >= io_base));

endmodule

// File: tb/sim_bridge_window_decoder.sv
`timescale 1ns/1ps
module sim_bridge_window_decoder;
  localparam bit IO32 = 1'b1, PREF64 = 1'b1;

  logic clk = 0, rst_n = 0, cfg_wr = 0, fwd_off = 0, dec_io = 0;
  logic [2:0] cfg_addr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [63:0] dec_addr = 0;
  logic [1:0] dec_hit;
  logic sbr_pulse;
  int nchk = 0, nfail = 0;
  logic [31:0] m [8];

  always #2.5 clk = ~clk;

  bridge_window_decoder #(.IO32(IO32), .PREF64(PREF64)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fwd_off(fwd_off), .dec_addr(dec_addr), .dec_io(dec_io),
    .dec_hit(dec_hit), .sbr_pulse(sbr_pulse));

  function automatic logic [31:0] wmask(int i);
    case (i)
      2: return 32'h0000F0F0;
      3: return IO32 ? 32'hFFFFFFFF : 32'h0;
      4, 5: return 32'hFFF0FFF0;
      6, 7: return PREF64 ? 32'hFFFFFFFF : 32'h0;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] tbits(int i);
    if (i == 2) return IO32 ? 32'h00000101 : 32'h0;
    if (i == 5) return PREF64 ? 32'h00010001 : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic [63:0] bnd(int k);
    case (k)
      0: return {32'h0, m[3][15:0], m[2][7:4], 12'h000};
      1: return {32'h0, m[3][31:16], m[2][15:12], 12'hFFF};
      2: return {32'h0, m[4][15:4], 20'h00000};
      3: return {32'h0, m[4][31:20], 20'hFFFFF};
      4: return {m[6], m[5][15:4], 20'h00000};
      default: return {m[7], m[5][31:20], 20'hFFFFF};
    endcase
  endfunction

  function automatic logic [1:0] exp_hit(logic [63:0] a, logic io);
    logic lo = (a[63:32] == 0);
    if (!io && m[0][1] && bnd(5) >= bnd(4) && a >= bnd(4) && a <= bnd(5)) return 2'd3;
    if (!io && m[0][1] && lo && bnd(3) >= bnd(2) && a >= bnd(2) && a <= bnd(3)) return 2'd2;
    if (io && m[0][0] && lo && bnd(1) >= bnd(0) && a >= bnd(0) && a <= bnd(1)) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int i, logic [3:0] be, logic [31:0] d);
    logic ep;
    logic [31:0] bm;
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 3'(i); cfg_be = be; cfg_wdata = d;
    ep = (i == 0) && be[2] && d[22] && !m[0][22];
    bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & wmask(i);
    m[i] = (m[i] & ~bm) | (d & bm);
    @(negedge clk);
    cfg_wr = 0;
    chk("R9 pulse", {63'h0, sbr_pulse}, {63'h0, ep});
  endtask

  task automatic off();
    @(negedge clk);
    fwd_off = 1;
    m[2] = 32'h000000F0; m[3] = IO32 ? 32'h0000FFFF : 32'h0;
    m[4] = 32'h0000FFF0; m[5] = 32'h0000FFF0; m[6] = 0; m[7] = 0;
    @(negedge clk);
    fwd_off = 0;
  endtask

  task automatic rd(string req, int i, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = 3'(i);
    #1;
    chk(req, {32'h0, cfg_rdata}, {32'h0, exp});
  endtask

  task automatic dq(string req, logic [63:0] a, logic io, logic [1:0] exp);
    @(negedge clk);
    dec_addr = a; dec_io = io;
    #1;
    chk(req, {62'h0, dec_hit}, {62'h0, exp});
    chk(req, {62'h0, dec_hit}, {62'h0, exp_hit(a, io)});
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    for (int i = 0; i < 8; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) rd("R1 reset", i, tbits(i));
    chk("R1 no pulse", {63'h0, sbr_pulse}, 64'h0);

    wr(1, 4'b0101, 32'hA1B2C3D4);
    rd("R2 byte enables", 1, 32'h00B200D4);
    wr(2, 4'hF, 32'hFFFFFFFF);
    rd("R2 read-only type", 2, 32'h0000F1F1);

    wr(0, 4'b0001, 32'h1);
    wr(2, 4'b0011, 32'h00003020);
    wr(3, 4'hF, 32'h00010001);
    dq("R3 io base", 64'h12000, 1, 2'd1);
    dq("R3 io limit", 64'h13FFF, 1, 2'd1);
    dq("R3 below", 64'h11FFF, 1, 2'd0);
    dq("R3 above", 64'h14000, 1, 2'd0);
    dq("R3 high bits", 64'h1_0001_2000, 1, 2'd0);

    wr(0, 4'b0001, 32'h3);
    wr(4, 4'hF, 32'h12501230);
    dq("R4 mem base", 64'h1230_0000, 0, 2'd2);
    dq("R4 mem limit", 64'h125F_FFFF, 0, 2'd2);
    dq("R4 below", 64'h122F_FFFF, 0, 2'd0);
    dq("R4 above", 64'h1260_0000, 0, 2'd0);
    dq("R4 upper bits", 64'h1_1230_0000, 0, 2'd0);

    wr(5, 4'hF, 32'h12401240);
    dq("R8 overlap", 64'h1245_0000, 0, 2'd3);
    dq("R8 mem only", 64'h1235_0000, 0, 2'd2);
    wr(7, 4'hF, 32'h2);
    dq("R5 above 4G", 64'h1_0000_0000, 0, 2'd3);
    dq("R5 limit", 64'h2_124F_FFFF, 0, 2'd3);
    dq("R5 past limit", 64'h2_1250_0000, 0, 2'd0);

    wr(0, 4'b0001, 32'h1);
    dq("R6 mem off", 64'h1230_0000, 0, 2'd0);
    dq("R6 io on", 64'h12000, 1, 2'd1);
    wr(0, 4'b0001, 32'h2);
    dq("R6 io off", 64'h12000, 1, 2'd0);
    dq("R6 mem on", 64'h1230_0000, 0, 2'd2);

    wr(7, 4'hF, 32'h0);
    wr(5, 4'hF, 32'h0);
    wr(4, 4'hF, 32'h12001230);
    dq("R7 inverted", 64'h1230_0000, 0, 2'd0);
    dq("R7 inverted low", 64'h1200_0000, 0, 2'd0);

    wr(4, 4'hF, 32'h40204010);
    dq("R11 new window", 64'h4020_0000, 0, 2'd2);
    dq("R11 new base", 64'h4010_0000, 0, 2'd2);
    dq("R11 old gone", 64'h1230_0000, 0, 2'd0);

    wr(0, 4'b0100, 32'h00400000);
    @(negedge clk);
    chk("R9 one cycle", {63'h0, sbr_pulse}, 64'h0);
    wr(0, 4'b0100, 32'h00400000);
    wr(0, 4'b0100, 32'h0);
    wr(0, 4'b0100, 32'h00400000);

    off();
    wr(0, 4'b0001, 32'h3);
    rd("R10 io word", 2, 32'h000001F1);
    rd("R10 io upper", 3, 32'h0000FFFF);
    rd("R10 mem", 4, 32'h0000FFF0);
    rd("R10 pref", 5, 32'h0001FFF1);
    rd("R10 pref upper", 7, 32'h0);
    dq("R10 mem closed", 64'h4020_0000, 0, 2'd0);
    dq("R10 io closed", 64'h12000, 1, 2'd0);
    dq("R10 top", 64'hFFF0_0000, 0, 2'd0);

    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 40;
      if (op == 0) off();
      else if (op < 16) wr($urandom % 8, 4'($urandom), $urandom);
      else if (op < 20) begin
        int i = $urandom % 8;
        rd("R2 random read", i, m[i] | tbits(i));
      end else begin
        int k = $urandom % 8;
        logic [63:0] a;
        if (k < 6) a = bnd(k) + 64'($urandom % 3) - 64'd1;
        else if (k == 6) a = {32'h0, $urandom};
        else a = {$urandom % 4, $urandom};
        dec_addr = a;
        @(negedge clk);
        dec_io = $urandom % 2;
        #1;
        chk("R8 random decode", {62'h0, dec_hit}, {62'h0, exp_hit(a, dec_io)});
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule